// File: doc/BRIEF.md
# PCI configuration address generator

This block turns a configuration request into the two values that a host bridge needs before it can run a PCI configuration cycle. The request is a bus number, a device/function byte and a register offset. The block produces a 32-bit address word and a 32-bit map word. The map word selects the configuration cycle type and states what the two low address bits are.

A request on bus 0 becomes a type 0 cycle. The device is selected by a single set bit, and the function number sits just below that bit. Only part of the one-hot select fits into the address word. For high slot numbers the select bit moves into the upper bits of the map word instead. A request on any other bus becomes a type 1 cycle, where the bus, slot and function are packed as fields. In both cases the register offset is added to the address.

Arguments arrive on ports wider than a byte, so values above 255 can be presented. Any such value is rejected with an error flag, and both output words are zero for that request. A start strobe captures the request. One cycle later the results appear together with a one-cycle done pulse, and they are held until the next strobe. Running the bus cycle itself is left to other logic.

Top module: `cfg_addr_gen`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `start` high, and low in every other cycle.
- R2: A legal request with bus number 0 gives `map_word[0]`=0 (type 0), and a legal request with any other bus number gives `map_word[0]`=1 (type 1). For every legal request, `map_word[3:1]` is 3'b101.
- R3: For a type 0 request, `cfg_addr[10:8]` equals `devfn[2:0]` (the function number).
- R4: For a type 0 request whose slot `devfn[7:3]` is 12 or less, `cfg_addr` bit (slot+11) is the only bit set in `cfg_addr[31:11]`, and `map_word[31:4]` is zero.
- R5: For a type 0 request whose slot is 13 or more, `map_word` bit (slot-5) is set, and `cfg_addr[31:11]` is zero.
- R6: For a type 1 request, `cfg_addr[31:8]` equals `{8'h00, bus[7:0], devfn[7:0]}`, and `map_word` is 32'h0000_000B.
- R7: For every legal request, `cfg_addr[7:0]` equals the register offset.
- R8: If bus, devfn or offset is above 255, then `arg_err` is 1 and both `cfg_addr` and `map_word` are zero. A legal request gives `arg_err`=0.
- R9: While reset is asserted, and after it is released, `done`, `arg_err`, `cfg_addr` and `map_word` are all zero until the first request.
- R10: The results of the last request stay unchanged while `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Captures the request arguments |
| bus_num | input | ARG_W | Bus number |
| devfn | input | ARG_W | Device (bits 7:3) and function (bits 2:0) |
| reg_off | input | ARG_W | Configuration register offset |
| done | output | 1 | One-cycle pulse when the results are valid |
| arg_err | output | 1 | An argument of the last request was above 255 |
| cfg_addr | output | 32 | Configuration address word |
| map_word | output | 32 | Map value: cycle type, low-bit mode and high select bits |

## Verification
The assertions assume that `start` is a clean synchronous level. When `done` is high, they assume the arguments that were captured are still visible through `$past` of the ports, one cycle back. The bench drives every input on the falling edge and holds `start` for exactly one cycle per request. It keeps the arguments stable through the capture edge. It also waits for the internal reset release before it sends the first request. Illegal values are sent on each of the three arguments separately, using port values that the 10-bit width can carry.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned SLOT_W       = 5;
  localparam int unsigned FUNC_W       = 3;
  localparam int unsigned LOW_SLOT_MAX = 12;
  localparam int unsigned ADDR_SEL_OFS = 11;
  localparam int unsigned MAP_SEL_OFS  = 5;
  localparam logic [2:0]  CYC_CONFIG   = 3'b101;

  typedef enum logic {
    CYC_TYPE0 = 1'b0,
    CYC_TYPE1 = 1'b1
  } cyc_type_e;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] map;
  } cfg_words_t;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_arg_check.sv
module cfg_arg_check #(
  parameter int unsigned ARG_W  = 10,
  parameter int unsigned N_ARGS = 3
) (
  input  logic [N_ARGS-1:0][ARG_W-1:0] args,
  output logic                         illegal
);
  localparam int unsigned LIMIT_W = 8;
  logic [N_ARGS-1:0] over;

  for (genvar g = 0; g < N_ARGS; g++) begin : g_arg
    if (ARG_W > LIMIT_W) begin : g_wide
      assign over[g] = |args[g][ARG_W-1:LIMIT_W];
    end else begin : g_narrow
      assign over[g] = 1'b0;
    end
  end

  assign illegal = |over;
endmodule

// File: rtl/cfg_type0_enc.sv
module cfg_type0_enc
  import cfg_addr_pkg::*;
(
  input  logic [BYTE_W-1:0] devfn,
  input  logic [BYTE_W-1:0] offset,
  output cfg_words_t        words
);
  logic [SLOT_W-1:0] slot;
  logic [FUNC_W-1:0] func;
  logic [WORD_W-1:0] addr_sel;
  logic [WORD_W-1:0] map_sel;

  assign slot = devfn[BYTE_W-1:FUNC_W];
  assign func = devfn[FUNC_W-1:0];

  always_comb begin
    addr_sel = '0;
    map_sel  = '0;
    if (32'(slot) <= LOW_SLOT_MAX) addr_sel = WORD_W'(1) << (32'(slot) + ADDR_SEL_OFS);
    else                           map_sel  = WORD_W'(1) << (32'(slot) - MAP_SEL_OFS);
  end

  always_comb begin
    words.addr = (addr_sel | (WORD_W'(func) << BYTE_W)) + WORD_W'(offset);
    words.map  = map_sel | WORD_W'({CYC_CONFIG, CYC_TYPE0});
  end
endmodule

// File: rtl/cfg_type1_enc.sv
module cfg_type1_enc
  import cfg_addr_pkg::*;
(
  input  logic [BYTE_W-1:0] bus_num,
  input  logic [BYTE_W-1:0] devfn,
  input  logic [BYTE_W-1:0] offset,
  output cfg_words_t        words
);
  localparam int unsigned BUS_LSB = 2 * BYTE_W;

  always_comb begin
    words.addr = ((WORD_W'(bus_num) << BUS_LSB) | (WORD_W'(devfn) << BYTE_W))
                 + WORD_W'(offset);
    words.map  = WORD_W'({CYC_CONFIG, CYC_TYPE1});
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_addr_pkg::*;
#(
  parameter int unsigned ARG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ARG_W-1:0] bus_num,
  input  logic [ARG_W-1:0] devfn,
  input  logic [ARG_W-1:0] reg_off,
  output logic             done,
  output logic             arg_err,
  output logic [WORD_W-1:0] cfg_addr,
  output logic [WORD_W-1:0] map_word
);
  localparam int unsigned N_ARGS = 3;

  logic       srst_n;
  logic       illegal;
  cfg_words_t t0_words, t1_words, sel_words;
  cfg_words_t words_d, words_q;
  logic       err_d, err_q, done_d, done_q;
  logic [N_ARGS-1:0][ARG_W-1:0] arg_vec;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign arg_vec = {reg_off, devfn, bus_num};

  cfg_arg_check #(.ARG_W(ARG_W), .N_ARGS(N_ARGS)) u_chk (
    .args(arg_vec), .illegal(illegal)
  );

  cfg_type0_enc u_t0 (
    .devfn(devfn[BYTE_W-1:0]), .offset(reg_off[BYTE_W-1:0]), .words(t0_words)
  );

  cfg_type1_enc u_t1 (
    .bus_num(bus_num[BYTE_W-1:0]), .devfn(devfn[BYTE_W-1:0]),
    .offset(reg_off[BYTE_W-1:0]), .words(t1_words)
  );

  always_comb begin
    sel_words = (bus_num[BYTE_W-1:0] == '0) ? t0_words : t1_words;
    done_d    = start;
    words_d   = words_q;
    err_d     = err_q;
    if (start) begin
      err_d   = illegal;
      words_d = illegal ? '0 : sel_words;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      words_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q  <= done_d;
      if (start) begin
        words_q <= words_d;
        err_q   <= err_d;
      end
    end
  end

  assign done     = done_q;
  assign arg_err  = err_q;
  assign cfg_addr = words_q.addr;
  assign map_word = words_q.map;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    !start |=> !done); // R1
  AST_CFG_TYPE_FIELD: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !arg_err) |-> (map_word[3:1] == CYC_CONFIG)); // R2
  AST_TYPE_BY_BUS: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !arg_err) |-> (map_word[0] == ($past(bus_num) != '0))); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !arg_err && !map_word[0]) |->
      ($countones({cfg_addr[31:11], map_word[31:8]}) == 1)); // R4
  AST_TYPE1_FIELDS: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !arg_err && map_word[0]) |->
      (cfg_addr[23:8] == {$past(bus_num[7:0]), $past(devfn[7:0])})); // R6
  AST_OFFSET_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !arg_err) |-> (cfg_addr[7:0] == $past(reg_off[7:0]))); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    arg_err |-> (cfg_addr == '0 && map_word == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    !start |=> ($stable(cfg_addr) && $stable(map_word) && $stable(arg_err))); // R10
endmodule

// File: tb/cfg_addr_gen_tb.sv
module cfg_addr_gen_tb;
  localparam int unsigned ARG_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [ARG_W-1:0] bus_num = '0;
  logic [ARG_W-1:0] devfn = '0;
  logic [ARG_W-1:0] reg_off = '0;
  logic             done, arg_err;
  logic [31:0]      cfg_addr, map_word;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_addr_gen #(.ARG_W(ARG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_num(bus_num), .devfn(devfn),
    .reg_off(reg_off), .done(done), .arg_err(arg_err), .cfg_addr(cfg_addr),
    .map_word(map_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_words(input int b, input int df, input int off,
                              output logic [31:0] ea, output logic [31:0] em,
                              output logic ee);
    int slot;
    ee = (b > 255) || (df > 255) || (off > 255);
    slot = (df >> 3) & 31;
    if (ee) begin
      ea = 0; em = 0;
    end else if (b == 0) begin
      em = 32'hA;
      ea = ((df & 7) << 8) + off;
      if (slot <= 12) ea = ea | (32'h1 << (slot + 11));
      else            em = em | (32'h1 << (slot - 5));
    end else begin
      em = 32'hB;
      ea = (b << 16) + (df << 8) + off;
    end
  endtask

  task automatic run_req(input string req, input int b, input int df, input int off);
    logic [31:0] ea, em;
    logic ee;
    expect_words(b, df, off, ea, em, ee);
    @(negedge clk);
    bus_num = ARG_W'(b); devfn = ARG_W'(df); reg_off = ARG_W'(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " addr"}, cfg_addr, ea);
    chk({req, " map"}, map_word, em);
    chk({req, " err"}, 32'(arg_err), 32'(ee));
    bus_num = '1; devfn = '0; reg_off = '1;
    @(negedge clk);
    chk("R1 done drops", 32'(done), 32'd0);
    chk("R10 addr held", cfg_addr, ea);
    chk("R10 map held", map_word, em);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R9 done at reset", 32'(done), 0);
    chk("R9 err at reset", 32'(arg_err), 0);
    chk("R9 addr at reset", cfg_addr, 0);
    chk("R9 map at reset", map_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 addr after release", cfg_addr, 0);
    chk("R9 done after release", 32'(done), 0);
  endtask

  task automatic test_type0();
    run_req("R3 R4 R7 slot0 fn5", 0, (0 << 3) | 5, 8'h04);
    run_req("R4 slot12 fn1", 0, (12 << 3) | 1, 8'h3C);
    run_req("R5 slot13 fn2", 0, (13 << 3) | 2, 8'h10);
    run_req("R5 slot31 fn7", 0, (31 << 3) | 7, 8'hFF);
    run_req("R2 R4 slot7 fn0", 0, 7 << 3, 0);
  endtask

  task automatic test_type1();
    run_req("R2 R6 bus1", 1, 8'hA5, 8'h08);
    run_req("R6 R7 bus255", 255, 8'hFF, 8'hFC);
  endtask

  task automatic test_illegal();
    run_req("R8 bus256", 256, 8'h10, 0);
    run_req("R8 devfn300", 0, 300, 4);
    run_req("R8 offset511", 3, 8'h08, 511);
    run_req("R8 legal after error", 0, 8'h08, 8'h20);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_type0();
    test_type1();
    test_illegal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule